// File: doc/BRIEF.md
# Framed Signalling-Channel Byte Access Controller

This block sits between a slow signalling channel, carried as one or two bits in every frame of a TDM serial bus, and an 8-bit processor register. On the receive side it gathers the channel bits of consecutive frames into a shadow shift register. At the last frame of every byte period it copies that shadow into a read register. On the transmit side it keeps the last byte written by software and sends it out, one or two bits per frame, starting at each byte boundary. The byte is sent again until software writes a new one.

A frame counter, cleared by reset, divides the frames into byte periods: four frames at the fast rate (two bits per frame) and eight frames at the slow rate (one bit per frame). The last frame of each period is the reference frame. In the reference frame the block raises an interrupt at a fixed bit cell. This tells software that a new read byte is ready and that a write will be picked up at the next boundary. The rate bit and the channel enable bit are taken only at a byte boundary. When the channel is disabled, both the transmit slot and the interrupt pin are released, but reception keeps running.

The frame pulse `frm_pulse` starts cell 0 of a frame. Each `cell_tick` starts the next bit cell. A tick in the same cycle as a frame pulse is ignored.

Top module: `dchan_byte_ctrl`

## Requirements
- R1: At the fast rate (`rate8_sel` taken as 0), each frame's two received bits are sampled on the first `cell_tick` of that frame, with `rx_bits[1]` as the earlier bit. The byte on `rd_data` after the reference frame holds, from bits 7:6 down to bits 1:0, the pairs of frames n-3, n-2, n-1 and n, with the earlier bit in the more significant position.
- R2: At the slow rate (`rate8_sel` taken as 1), one bit per frame is received on `rx_bits[1]` and sent on `tx_bits[1]`. A byte spans eight frames, and the oldest bit is bit 7.
- R3: A byte written with `reg_wr` in reference frame n is sent in frames n+1 to n+4 as pairs, bits 7:6 first. `tx_bits[1]` carries the earlier bit of each pair. `tx_bits` changes only on the cycle after a frame pulse.
- R4: When no new byte is written, the held transmit byte is sent again in every following byte period.
- R5: After reset the transmit byte is all ones, so `tx_bits` is 2'b11. After reset `irq`, `tx_oe` and `irq_oe` are 0, the rate is the fast one, and the first frame pulse starts a new byte period.
- R6: `irq` rises one cycle after the `cell_tick` that starts the third bit cell of the reference frame at the fast rate. At the slow rate it rises after the tick that starts the second bit cell.
- R7: `irq` falls on the cycle after a `reg_rd` or `reg_wr`, or on the cycle after the next frame pulse, whichever comes first.
- R8: While the channel is disabled, `tx_oe` and `irq_oe` are 0, and received bits still reach `rd_data`.
- R9: `rate8_sel` and `chan_en` are taken only at the frame pulse that ends a reference frame. A change in the middle of a byte period has no effect until then.
- R10: At the slow rate `tx_bits[0]` is held at 1.
- R11: `rd_data` changes only on the cycle after the first `cell_tick` of a reference frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_pulse | input | 1 | One-cycle strobe at the start of each frame |
| cell_tick | input | 1 | One-cycle strobe at the start of each later bit cell |
| rx_bits | input | 2 | Received channel bits of the current frame, earlier bit in [1] |
| rate8_sel | input | 1 | 1 selects one bit per frame, 0 selects two |
| chan_en | input | 1 | Channel enable for the transmit slot and interrupt pin |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| wr_data | input | BYTE_W | Byte written with `reg_wr` |
| tx_bits | output | 2 | Transmit channel bits of the current frame, earlier bit in [1] |
| tx_oe | output | 1 | Drive enable for the transmit slot |
| rd_data | output | BYTE_W | Read register |
| irq | output | 1 | Byte-window interrupt |
| irq_oe | output | 1 | Drive enable for the interrupt pin |

## Verification
The bench builds the block with its defaults: an 8-bit register, the receive sample in the first cell, and the interrupt in cell 2 or cell 1. Each frame carries four bit cells, three clocks apart. These values place the interrupt and both access kinds inside one short frame. They also allow a full slow-rate byte period, and a rate and enable change that crosses a boundary, all within a few hundred cycles. The bench changes the rate and the enable mid-period and checks that nothing moves until the boundary. It keeps one byte on air across several periods at both rates.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  typedef struct packed {
    logic rate8;
    logic en;
  } dchan_mode_t;

  // Slow rate carries one bit per frame; the spare lane idles high.
  function automatic logic [1:0] tx_pick(input logic r8, input logic [1:0] top2);
    return r8 ? {top2[1], 1'b1} : top2;
  endfunction

endpackage

// File: rtl/dchan_frame_seq.sv
module dchan_frame_seq
  import dchan_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int CELL_W     = 4,
  parameter int RX_CELL    = 1,
  parameter int IRQ_CELL16 = 2,
  parameter int IRQ_CELL8  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frm_pulse,
  input  logic        cell_tick,
  input  logic        rate8_in,
  input  logic        en_in,
  output dchan_mode_t mode_q,
  output logic        boundary,
  output logic        ref_frame,
  output logic        rx_take,
  output logic        irq_hit
);
  localparam int FRM16 = BYTE_W / 2;
  localparam int FRM8  = BYTE_W;
  localparam int IDX_W = $clog2(FRM8);
  localparam logic [IDX_W-1:0]  LAST16 = IDX_W'(FRM16 - 1);
  localparam logic [IDX_W-1:0]  LAST8  = IDX_W'(FRM8 - 1);
  localparam logic [CELL_W-1:0] RX_AT  = CELL_W'(RX_CELL - 1);
  localparam logic [CELL_W-1:0] IRQ16  = CELL_W'(IRQ_CELL16 - 1);
  localparam logic [CELL_W-1:0] IRQ8   = CELL_W'(IRQ_CELL8 - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last;
  logic [CELL_W-1:0] cell_q;
  logic              tick_ok;

  assign last      = mode_q.rate8 ? LAST8 : LAST16;
  assign ref_frame = (idx_q == last);
  assign boundary  = frm_pulse && ref_frame;
  assign tick_ok   = cell_tick && !frm_pulse;
  assign rx_take   = tick_ok && (cell_q == RX_AT);
  assign irq_hit   = tick_ok && ref_frame && (cell_q == (mode_q.rate8 ? IRQ8 : IRQ16));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= LAST16;
      cell_q <= '0;
      mode_q <= '0;
    end else if (frm_pulse) begin
      cell_q <= '0;
      if (ref_frame) begin
        idx_q        <= '0;
        mode_q.rate8 <= rate8_in;
        mode_q.en    <= en_in;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (tick_ok && (cell_q != '1)) begin
      cell_q <= cell_q + 1'b1;
    end
  end

endmodule

// File: rtl/dchan_rx_path.sv
module dchan_rx_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rx_take,
  input  logic              ref_frame,
  input  logic              rate8,
  input  logic [1:0]        rx_bits,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] shadow_q;
  logic [BYTE_W-1:0] shadow_nx;

  always_comb begin
    if (rate8) shadow_nx = {shadow_q[BYTE_W-2:0], rx_bits[1]};
    else       shadow_nx = {shadow_q[BYTE_W-3:0], rx_bits};
  end

  // Receive side carries no reset value.
  always_ff @(posedge clk) begin
    if (rx_take) begin
      shadow_q <= shadow_nx;
      if (ref_frame) rd_data <= shadow_nx;
    end
  end

endmodule

// File: rtl/dchan_tx_path.sv
module dchan_tx_path
  import dchan_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_pulse,
  input  logic              boundary,
  input  logic              rate8_act,
  input  logic              rate8_next,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [1:0]        tx_bits
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] src;
  logic              r8;

  always_comb begin
    src = boundary ? hold_q : shift_q;
    r8  = boundary ? rate8_next : rate8_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '1;
      shift_q <= '1;
      tx_bits <= 2'b11;
    end else begin
      if (wr_en) hold_q <= wr_data;
      if (frm_pulse) begin
        tx_bits <= tx_pick(r8, src[BYTE_W-1 -: 2]);
        shift_q <= r8 ? {src[BYTE_W-2:0], 1'b1} : {src[BYTE_W-3:0], 2'b11};
      end
    end
  end

endmodule

// File: rtl/dchan_irq_ctl.sv
module dchan_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic irq_hit,
  input  logic frm_pulse,
  input  logic reg_rd,
  input  logic reg_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)                               irq <= 1'b0;
    else if (irq_hit)                      irq <= 1'b1;
    else if (frm_pulse || reg_rd || reg_wr) irq <= 1'b0;
  end
endmodule

// File: rtl/dchan_byte_ctrl.sv
module dchan_byte_ctrl
  import dchan_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int CELL_W     = 4,
  parameter int RX_CELL    = 1,
  parameter int IRQ_CELL16 = 2,
  parameter int IRQ_CELL8  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_pulse,
  input  logic              cell_tick,
  input  logic [1:0]        rx_bits,
  input  logic              rate8_sel,
  input  logic              chan_en,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [1:0]        tx_bits,
  output logic              tx_oe,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq,
  output logic              irq_oe
);
  dchan_mode_t mode_q;
  logic        boundary;
  logic        ref_frame;
  logic        rx_take;
  logic        irq_hit;

  dchan_frame_seq #(
    .BYTE_W(BYTE_W), .CELL_W(CELL_W), .RX_CELL(RX_CELL),
    .IRQ_CELL16(IRQ_CELL16), .IRQ_CELL8(IRQ_CELL8)
  ) u_seq (
    .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .cell_tick(cell_tick),
    .rate8_in(rate8_sel), .en_in(chan_en), .mode_q(mode_q),
    .boundary(boundary), .ref_frame(ref_frame), .rx_take(rx_take), .irq_hit(irq_hit)
  );

  dchan_rx_path #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rx_take(rx_take), .ref_frame(ref_frame),
    .rate8(mode_q.rate8), .rx_bits(rx_bits), .rd_data(rd_data)
  );

  dchan_tx_path #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .boundary(boundary),
    .rate8_act(mode_q.rate8), .rate8_next(rate8_sel),
    .wr_en(reg_wr), .wr_data(wr_data), .tx_bits(tx_bits)
  );

  dchan_irq_ctl u_irq (
    .clk(clk), .rst(rst), .irq_hit(irq_hit), .frm_pulse(frm_pulse),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .irq(irq)
  );

  assign tx_oe  = mode_q.en;
  assign irq_oe = mode_q.en;

endmodule

// File: rtl/dchan_byte_ctrl_chk.sv
module dchan_byte_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_pulse,
  input logic              cell_tick,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [1:0]        tx_bits,
  input logic              tx_oe,
  input logic [BYTE_W-1:0] rd_data,
  input logic              irq
);
  // R7
  frm_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    frm_pulse |=> !irq);

  // R7
  access_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((reg_rd || reg_wr) && !cell_tick) |=> !irq);

  // R6
  irq_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cell_tick));

  // R3
  tx_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !frm_pulse |=> $stable(tx_bits));

  // R9
  oe_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_oe) |-> $past(frm_pulse));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> $past(cell_tick));

endmodule

bind dchan_byte_ctrl dchan_byte_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .cell_tick(cell_tick),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .tx_bits(tx_bits), .tx_oe(tx_oe),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_dchan_byte_ctrl.sv
module tb_dchan_byte_ctrl;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_pulse = 1'b0, cell_tick = 1'b0;
  logic [1:0] rx_bits = 2'b00;
  logic rate8_sel = 1'b0, chan_en = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [BW-1:0] wr_data = '0;
  logic [1:0] tx_bits;
  logic tx_oe, irq, irq_oe;
  logic [BW-1:0] rd_data;

  always #2.5 clk = ~clk;

  dchan_byte_ctrl dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_idx, m_cell;
  bit m_r8, m_en, m_irq, m_live, m_rd_valid;
  logic [BW-1:0] m_hold, m_rd;
  logic [1:0] m_tx;
  bit m_txq[$];
  bit m_rxq[$];

  always @(posedge clk) begin
    int last;
    bit setirq;
    bit b1, b0;
    if (rst) begin
      m_idx = 3; m_cell = 0; m_r8 = 0; m_en = 0; m_irq = 0;
      m_hold = '1; m_tx = 2'b11; m_txq.delete(); m_rxq.delete();
      m_rd_valid = 0; m_live = 1;
    end else begin
      last = m_r8 ? BW - 1 : BW / 2 - 1;
      setirq = 0;
      if (frm_pulse) begin
        if (m_idx == last) begin
          m_r8 = rate8_sel; m_en = chan_en; m_idx = 0;
          m_txq.delete();
          for (int i = BW - 1; i >= 0; i--) m_txq.push_back(m_hold[i]);
        end else m_idx++;
        m_cell = 0;
        b1 = (m_txq.size() > 0) ? m_txq.pop_front() : 1'b1;
        if (m_r8) b0 = 1'b1;
        else b0 = (m_txq.size() > 0) ? m_txq.pop_front() : 1'b1;
        m_tx = {b1, b0};
      end else if (cell_tick) begin
        if (m_cell == 0) begin
          m_rxq.push_back(rx_bits[1]);
          if (!m_r8) m_rxq.push_back(rx_bits[0]);
          while (m_rxq.size() > BW) void'(m_rxq.pop_front());
          if (m_idx == last && m_rxq.size() == BW) begin
            for (int i = 0; i < BW; i++) m_rd[BW-1-i] = m_rxq[i];
            m_rd_valid = 1;
          end
        end
        if (m_idx == last && m_cell == (m_r8 ? 0 : 1)) setirq = 1;
        if (m_cell < 15) m_cell++;
      end
      if (reg_wr) m_hold = wr_data;
      if (setirq) m_irq = 1;
      else if (frm_pulse || reg_rd || reg_wr) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && m_live) begin
      chk("R3 tx_bits vs model", 32'(tx_bits), 32'(m_tx));
      chk("R8 tx_oe vs model", 32'(tx_oe), 32'(m_en));
      chk("R8 irq_oe vs model", 32'(irq_oe), 32'(m_en));
      chk("R6/R7 irq vs model", 32'(irq), 32'(m_irq));
      if (m_rd_valid) chk("R11 rd_data vs model", 32'(rd_data), 32'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  int fno = 0;
  logic [1:0] tx_log [0:39];
  bit oe_log [0:39];
  bit irq_c0, irq_c1, irq_acc;

  task automatic do_frame(input logic [1:0] rx, input bit do_rd, input bit do_wr,
                          input logic [BW-1:0] wd);
    rx_bits = rx;
    frm_pulse = 1'b1;
    @(posedge clk); #1 frm_pulse = 1'b0;
    @(negedge clk);
    tx_log[fno] = tx_bits;
    oe_log[fno] = tx_oe;
    for (int c = 0; c < 4; c++) begin
      repeat (2) @(posedge clk);
      #1 cell_tick = 1'b1;
      @(posedge clk); #1 cell_tick = 1'b0;
      @(negedge clk);
      if (c == 0) irq_c0 = irq;
      if (c == 1) irq_c1 = irq;
    end
    if (do_rd || do_wr) begin
      repeat (1) @(posedge clk);
      #1 reg_rd = do_rd; reg_wr = do_wr; wr_data = wd;
      @(posedge clk); #1 reg_rd = 1'b0; reg_wr = 1'b0;
      @(negedge clk);
      irq_acc = irq;
    end
    repeat (2) @(posedge clk);
    #1;
    fno++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp16 [0:3];
    logic [BW-1:0] slow_byte;
    bit slow_rx [0:7];
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R5 reset state
    chk("R5 tx_bits after reset", 32'(tx_bits), 32'h3);
    chk("R5 irq after reset", 32'(irq), 32'h0);
    chk("R5 tx_oe after reset", 32'(tx_oe), 32'h0);
    chk("R5 irq_oe after reset", 32'(irq_oe), 32'h0);
    @(posedge clk); #1;
    chan_en = 1'b1;

    // frames 0..3: fast rate, rx pairs 01,10,11,00
    do_frame(2'b01, 0, 0, '0);
    do_frame(2'b10, 0, 0, '0);
    do_frame(2'b11, 0, 0, '0);
    do_frame(2'b00, 1, 1, 8'hB4);
    // R6 fast rate: not after cell 1, set after cell 2
    chk("R6 irq before third cell", 32'(irq_c0), 32'h0);
    chk("R6 irq at third cell", 32'(irq_c1), 32'h1);
    // R7 access clears
    chk("R7 irq cleared by access", 32'(irq_acc), 32'h0);
    // R1 pair order
    chk("R1 read byte fast rate", 32'(rd_data), 32'h6C);
    for (int f = 0; f < 4; f++) chk("R5 all-ones transmit", 32'(tx_log[f]), 32'h3);
    chk("R9 enable taken at first boundary", 32'(oe_log[0]), 32'h1);

    // frames 4..11: 0xB4 sent, then re-sent
    exp16[0] = 2'b10; exp16[1] = 2'b11; exp16[2] = 2'b01; exp16[3] = 2'b00;
    for (int f = 4; f < 8; f++) do_frame(2'b11, 0, 0, '0);
    for (int f = 0; f < 4; f++) chk("R3 written byte pairs", 32'(tx_log[4+f]), 32'(exp16[f]));
    do_frame(2'b01, 0, 0, '0);
    rate8_sel = 1'b1; chan_en = 1'b0;    // mid-period change
    do_frame(2'b10, 0, 0, '0);
    do_frame(2'b00, 0, 0, '0);
    do_frame(2'b11, 0, 1, 8'h5A);
    for (int f = 0; f < 4; f++) chk("R4 byte re-sent", 32'(tx_log[8+f]), 32'(exp16[f]));
    chk("R9 enable held mid-period", 32'(oe_log[10]), 32'h1);
    chk("R9 enable held in reference frame", 32'(oe_log[11]), 32'h1);
    chk("R9 rate held mid-period", 32'(tx_log[11][0]), 32'(exp16[3][0]));

    // frames 12..19: slow rate, disabled
    slow_byte = 8'h5A;
    slow_rx[0] = 1; slow_rx[1] = 1; slow_rx[2] = 0; slow_rx[3] = 0;
    slow_rx[4] = 1; slow_rx[5] = 0; slow_rx[6] = 0; slow_rx[7] = 1;
    for (int f = 0; f < 8; f++) begin
      if (f == 6) chan_en = 1'b1;
      do_frame({slow_rx[f], 1'b0}, 0, 0, '0);
    end
    for (int f = 0; f < 8; f++) begin
      chk("R2 slow-rate transmit bit", 32'(tx_log[12+f][1]), 32'(slow_byte[7-f]));
      chk("R10 spare lane high", 32'(tx_log[12+f][0]), 32'h1);
    end
    chk("R8 tx_oe low when disabled", 32'(oe_log[13]), 32'h0);
    chk("R8 irq_oe low when disabled", 32'(irq_oe), 32'h0);
    chk("R2 R8 slow-rate read byte while disabled", 32'(rd_data), 32'hC9);

    // frames 20..27: slow rate, enabled, no new write
    for (int f = 0; f < 8; f++) do_frame(2'b10, 0, 0, '0);
    chk("R6 slow-rate irq at second cell", 32'(irq_c0), 32'h1);
    chk("R9 enable taken at boundary", 32'(oe_log[20]), 32'h1);
    for (int f = 0; f < 8; f++)
      chk("R4 slow-rate re-send", 32'(tx_log[20+f][1]), 32'(slow_byte[7-f]));
    chk("R7 irq held until frame pulse", 32'(irq), 32'h1);
    chk("R11 read byte all ones", 32'(rd_data), 32'hFF);

    // frame 28: pulse clears irq
    rate8_sel = 1'b0;
    do_frame(2'b00, 0, 0, '0);
    chk("R7 irq cleared by frame pulse", 32'(irq_c0), 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule